// File: doc/BRIEF.md
# Pseudo-Random Delay-Pair Modular Differencer

This block turns two sets of already-compensated path-delay values into a stream of small wrapped differences that a later stage uses for bit generation. One set holds delays measured for rising transitions and the other holds delays for falling transitions. Each set sits in its own small local memory, which is loaded through a write port while the block is idle.

A run starts with a 16-bit seed supplied from outside, for example the XOR of two nonces. A maximal-length LFSR seeded with that value chooses, for each output, which rising-edge entry is paired with which falling-edge entry. The block subtracts the falling value from the rising value and adds an optional signed offset. It then reduces the sum into the range 0 to M−1, where M is the programmed modulus. The reduction is a true mathematical modulo, so negative sums land on positive results. This removes the common path-length bias and keeps the small per-die variation.

The reduction adds or subtracts M once per clock instead of dividing. The number of cycles per result therefore depends on the size of the sum. Results leave on a valid/ready stream. After the programmed number of results has been taken, the block raises done.

Top module: `pair_diff_wrap`

## Requirements
- R1: After reset, busy, done and out_valid are all low.
- R2: Output k of a run uses LFSR state S(k). S(0) is the seed, and S(k+1) = {S(k)[14:0], S(k)[15]^S(k)[13]^S(k)[12]^S(k)[10]}. The rising entry is taken from address S(k)[5:0] and the falling entry from address S(k)[11:6].
- R3: A seed of zero is replaced by 16'hACE1, and the LFSR state is never zero while a run is in progress.
- R4: Each output equals (rise − fall + offset) mod M, always in 0..M−1. Negative sums are wrapped upward, so −5 mod 14 = 9.
- R5: offset is an 11-bit two's-complement value (−1024..1023) added before the reduction.
- R6: Every modulus from 14 to 30, and 64, is supported. A modulus below 2 acts as 2.
- R7: A run yields exactly out_count results and then holds done high, with busy low, until the next start. A start with out_count = 0 sets done on the next cycle and yields no results. done is low while a run is in progress.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R9: start is ignored while busy. seed, modulus, offset and out_count are captured when the run starts, so later changes to them have no effect on that run.
- R10: Memory writes (wr_fall = 0 selects the rising memory, 1 the falling memory) take effect only while the block is idle. Writes while busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the delay memories |
| wr_fall | input | 1 | Memory select: 0 rising, 1 falling |
| wr_addr | input | 6 | Write address |
| wr_data | input | 11 | Delay value to store |
| start | input | 1 | Begin a run (one cycle, idle only) |
| seed | input | 16 | LFSR seed |
| modulus | input | 7 | Wrap modulus M |
| offset | input | 11 | Signed offset added to each difference |
| out_count | input | 10 | Number of results in the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has finished |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 7 | Wrapped difference |

## Verification
The bench targets negative sums at the most negative offset. A design that truncated the sum or applied the remainder operator as-is would emit values above M−1 or miss the upward wrap. It also covers modulus 64 and modulus 1, where a wrong clamp or an off-by-one range test would either hang the reduction or leave a result equal to M. It checks a zero seed, which would lock a plain LFSR at zero and repeat one pair forever. Stalls from random backpressure would expose a result that changes while waiting. During a run the bench re-asserts start with new parameters and writes the memory. A design that obeyed either would produce a result sequence different from the one computed from the original seed and the original contents.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] ZERO_SEED_SUB = 16'hACE1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_REDUCE = 2'd2,
        ST_EMIT   = 2'd3
    } pdw_state_e;
endpackage

// File: rtl/pdw_lfsr_step.sv
module pdw_lfsr_step
    import pdw_pkg::*;
(
    input  logic [LFSR_W-1:0] cur,
    output logic [LFSR_W-1:0] nxt
);
    logic fb;

    always_comb begin
        fb  = cur[15] ^ cur[13] ^ cur[12] ^ cur[10];
        nxt = {cur[LFSR_W-2:0], fb};
    end
endmodule

// File: rtl/pdw_delay_store.sv
module pdw_delay_store #(
    parameter int VAL_W = 11,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [VAL_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [VAL_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [VAL_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = mem[raddr];
    end
endmodule

// File: rtl/pdw_wrap_step.sv
module pdw_wrap_step #(
    parameter int ACC_W = 13,
    parameter int MOD_W = 7
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [MOD_W-1:0] modv,
    output logic [ACC_W-1:0] acc_nxt,
    output logic             settled
);
    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] mod_s;
    logic                    neg;
    logic                    too_big;

    always_comb begin
        acc_s   = $signed(acc);
        mod_s   = $signed({{(ACC_W-MOD_W){1'b0}}, modv});
        neg     = acc[ACC_W-1];
        too_big = !neg && (acc_s >= mod_s);
        if (neg) begin
            acc_nxt = acc_s + mod_s;
        end else if (too_big) begin
            acc_nxt = acc_s - mod_s;
        end else begin
            acc_nxt = acc;
        end
        settled = !neg && !too_big;
    end
endmodule

// File: rtl/pair_diff_wrap.sv
module pair_diff_wrap
    import pdw_pkg::*;
#(
    parameter int VAL_W = 11,
    parameter int IDX_W = 6,
    parameter int MOD_W = 7,
    parameter int CNT_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_fall,
    input  logic [IDX_W-1:0]     wr_addr,
    input  logic [VAL_W-1:0]     wr_data,
    input  logic                 start,
    input  logic [LFSR_W-1:0]    seed,
    input  logic [MOD_W-1:0]     modulus,
    input  logic [VAL_W-1:0]     offset,
    input  logic [CNT_W-1:0]     out_count,
    output logic                 busy,
    output logic                 done,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [MOD_W-1:0]     out_data
);
    localparam int ACC_W = VAL_W + 2;
    localparam int N_MEM = 2;
    localparam logic [MOD_W-1:0] MIN_MOD = MOD_W'(2);

    typedef struct packed {
        pdw_state_e        state;
        logic [LFSR_W-1:0] lfsr;
        logic [MOD_W-1:0]  modv;
        logic [ACC_W-1:0]  off;
        logic [CNT_W-1:0]  left;
        logic [ACC_W-1:0]  acc;
        logic              done;
    } pdw_regs_t;

    pdw_regs_t st_d, st_q;

    logic [LFSR_W-1:0] lfsr_nxt;
    logic [ACC_W-1:0]  acc_step;
    logic              acc_settled;
    logic [IDX_W-1:0]  rd_idx  [N_MEM];
    logic [VAL_W-1:0]  rd_val  [N_MEM];
    logic              mem_we;

    assign rd_idx[0] = st_q.lfsr[IDX_W-1:0];
    assign rd_idx[1] = st_q.lfsr[2*IDX_W-1:IDX_W];
    assign mem_we    = wr_en && (st_q.state == ST_IDLE);

    generate
        for (genvar g = 0; g < N_MEM; g++) begin : g_store
            pdw_delay_store #(
                .VAL_W (VAL_W),
                .IDX_W (IDX_W)
            ) u_store (
                .clk   (clk),
                .we    (mem_we && (wr_fall == g[0])),
                .waddr (wr_addr),
                .wdata (wr_data),
                .raddr (rd_idx[g]),
                .rdata (rd_val[g])
            );
        end
    endgenerate

    pdw_lfsr_step u_lfsr (
        .cur (st_q.lfsr),
        .nxt (lfsr_nxt)
    );

    pdw_wrap_step #(
        .ACC_W (ACC_W),
        .MOD_W (MOD_W)
    ) u_wrap (
        .acc     (st_q.acc),
        .modv    (st_q.modv),
        .acc_nxt (acc_step),
        .settled (acc_settled)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.lfsr = (seed == '0) ? ZERO_SEED_SUB : seed;
                    st_d.modv = (modulus < MIN_MOD) ? MIN_MOD : modulus;
                    st_d.off  = {{2{offset[VAL_W-1]}}, offset};
                    st_d.left = out_count;
                    if (out_count == '0) begin
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.done  = 1'b0;
                        st_d.state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                st_d.acc   = $signed({2'b00, rd_val[0]})
                           - $signed({2'b00, rd_val[1]})
                           + $signed(st_q.off);
                st_d.lfsr  = lfsr_nxt;
                st_d.state = ST_REDUCE;
            end
            ST_REDUCE: begin
                if (acc_settled) begin
                    st_d.state = ST_EMIT;
                end else begin
                    st_d.acc = acc_step;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    st_d.left = st_q.left - CNT_W'(1);
                    if (st_q.left == CNT_W'(1)) begin
                        st_d.state = ST_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.state = ST_FETCH;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, lfsr: ZERO_SEED_SUB, modv: MIN_MOD,
                      off: '0, left: '0, acc: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.state != ST_IDLE);
    assign done      = st_q.done;
    assign out_valid = (st_q.state == ST_EMIT);
    assign out_data  = st_q.acc[MOD_W-1:0];
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker #(
    parameter int MOD_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              out_valid,
    input logic              out_ready,
    input logic [MOD_W-1:0]  out_data,
    input logic [MOD_W-1:0]  modulus,
    input logic [15:0]       lfsr
);
    logic [MOD_W-1:0] mod_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_seen <= MOD_W'(2);
        end else if (start && !busy) begin
            mod_seen <= (modulus < MOD_W'(2)) ? MOD_W'(2) : modulus;
        end
    end

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data < mod_seen);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !out_valid);

    p_valid_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready) || $past(start));

    p_lfsr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> lfsr != 16'h0000);
endmodule

bind pair_diff_wrap pdw_checker #(.MOD_W(MOD_W)) u_pdw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .modulus   (modulus),
    .lfsr      (st_q.lfsr)
);

// File: tb/test_pair_diff_wrap.sv
module test_pair_diff_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_fall = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic        start = 1'b0;
    logic [15:0] seed = '0;
    logic [6:0]  modulus = 7'd14;
    logic [10:0] offset = '0;
    logic [9:0]  out_count = '0;
    logic        busy, done, out_valid;
    logic        out_ready = 1'b0;
    logic [6:0]  out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int rise_m [64];
    int fall_m [64];

    pair_diff_wrap i_pair_diff_wrap (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fall(wr_fall),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .seed(seed),
        .modulus(modulus), .offset(offset), .out_count(out_count),
        .busy(busy), .done(done), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int wrap_mod(input int r, input int f, input int off, input int m);
        int e = (m < 2) ? 2 : m;
        int v = (r - f + off) % e;
        if (v < 0) v += e;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R7 watchdog expired actual=0 expected=1");
        report();
        $finish;
    end

    task automatic load_mem();
        for (int a = 0; a < 64; a++) begin
            for (int sel = 0; sel < 2; sel++) begin
                int v = int'($urandom_range(2047));
                @(negedge clk);
                wr_en = 1'b1; wr_fall = sel[0]; wr_addr = a[5:0]; wr_data = v[10:0];
                if (sel == 0) rise_m[a] = v; else fall_m[a] = v;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_case(input logic [15:0] sd, input int m, input int off,
                            input int cnt, input int rdy_pct, input bit disturb);
        logic [15:0] s = (sd == 16'h0) ? 16'hACE1 : sd;
        int k = 0;
        bit stall = 1'b0;
        bit dist_done = 1'b0;
        logic [6:0] held = '0;
        @(negedge clk);
        seed = sd; modulus = m[6:0]; offset = off[10:0]; out_count = cnt[9:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (cnt == 0) begin
            chk(done && !busy && !out_valid, "R7 zero count done", int'(done), 1);
            return;
        end
        chk(busy && !done, "R7 done low during run", int'(done), 0);
        while (k < cnt) begin
            if (stall) chk(out_valid && out_data == held, "R8 hold on stall", int'(out_data), int'(held));
            out_ready = ($urandom_range(99) < rdy_pct);
            start = 1'b0;
            wr_en = 1'b0;
            if (disturb && !dist_done && k == 1) begin
                logic [15:0] sn = lfsr_next(s);
                start = 1'b1; seed = ~sd; modulus = 7'd64; offset = 11'd0; out_count = 10'd3;
                wr_en = 1'b1; wr_fall = 1'b0; wr_addr = sn[5:0];
                wr_data = 11'(~rise_m[sn[5:0]]);
                dist_done = 1'b1;
            end
            if (out_valid && out_ready) begin
                int e = wrap_mod(rise_m[s[5:0]], fall_m[s[11:6]], off, m);
                chk(int'(out_data) == e, "R4 R2 wrapped pair value", int'(out_data), e);
                s = lfsr_next(s);
                k++;
                stall = 1'b0;
            end else begin
                stall = out_valid;
                held  = out_data;
            end
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0; out_ready = 1'b0;
        chk(done && !busy && !out_valid, "R7 done after last result", int'(done), 1);
        repeat (3) @(negedge clk);
        chk(done && !out_valid, "R7 no extra result", int'(out_valid), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        #1;
        chk(!busy && !done && !out_valid, "R1 reset state", int'({busy, done, out_valid}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !out_valid, "R1 after reset release", int'({busy, done, out_valid}), 0);
        load_mem();
        run_case(16'h1234, 14, 0, 20, 100, 1'b0);           // R2 R4 basic
        run_case(16'h8001, 30, -700, 24, 60, 1'b0);          // R5 negative offset, R8 stalls
        run_case(16'h00FF, 64, 1023, 16, 50, 1'b0);          // R6 modulus 64, max offset
        run_case(16'h7A5C, 22, -1024, 16, 70, 1'b0);         // R5 most negative offset
        run_case(16'h0000, 17, 5, 12, 100, 1'b0);            // R3 zero seed
        run_case(16'h4321, 1, 3, 10, 80, 1'b0);              // R6 modulus below 2
        run_case(16'h2222, 20, 0, 0, 100, 1'b0);             // R7 zero count
        run_case(16'hBEEF, 26, -50, 10, 100, 1'b1);          // R9 R10 disturbed run
        run_case(16'hBEEF, 26, -50, 10, 100, 1'b0);          // R10 memory unchanged
        for (int i = 0; i < 6; i++) begin
            int m = (i == 5) ? 64 : int'($urandom_range(30, 14));
            int off = int'($urandom_range(2047)) - 1024;
            logic [15:0] sd = 16'($urandom_range(65535));
            run_case(sd, m, off, 8 + i, 40 + 10 * i, 1'b0);  // R4 R6 random
        end
        report();
        $finish;
    end
endmodule